// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control half of a successive-approximation converter. Software programs it through a small write port with three registers. A control register holds the enable, start, auto-trigger, flag-clear, interrupt-enable and clock-divider fields. A select register holds the channel, the reference and the result alignment. A trigger register picks the auto-trigger source. The block divides the system clock down to a converter clock and times each conversion in converter clock ticks. It pulses `sampleStart` when a real conversion begins. When the timing is done, it raises `eocReq` and holds it until an external converter answers with `cvtValid` and a 10-bit code.

The block supports three ways to start a conversion: a software start, a rising edge on a selected trigger line, and a free-running mode that restarts immediately after each completion. The first conversion after the block is enabled carries a preparation phase. Channel and reference changes reach the converter only between conversions. The captured code is shown on a 16-bit readout, packed to the top or to the bottom according to an alignment bit that acts at once.

Top module: `adc_seq`

## Requirements
- R1: A control write (`regSel`=0) with bit 0 (enable) and bit 1 (start) both set, made while idle, makes `busy` high after that edge and starts a conversion. A control write with bit 1 clear starts nothing.
- R2: `busy` stays high for the whole conversion, including the handshake wait, and falls on the same edge that sets `flag`.
- R3: The first conversion after enable rises takes 25 converter ticks, and so does a start written together with the enable. Later conversions take 13 ticks. `eocReq` rises after the last tick, and `flag` is set one edge after `cvtValid` is seen with `eocReq`.
- R4: Control bits 7:5 hold the divider code c. One converter tick lasts 2^max(c,1) system clocks, counted from the edge that starts the conversion.
- R5: A control write with bit 0 clear aborts any conversion. `busy` and `eocReq` are low after that edge, and no result or flag follows.
- R6: `flag` sets when a result is captured. It clears on `irqAck`, or on a control write with bit 3 set. A control write with bit 3 clear leaves it unchanged.
- R7: `irq` is high exactly when `flag`, the interrupt enable (control bit 4) and `globalIe` are all high.
- R8: The select register (`regSel`=1; bits 3:0 channel, bits 5:4 reference) drives `activeChan`/`activeRef` while idle. A write made during a conversion shows there only from the completing edge.
- R9: Select bit 6 chooses the alignment. When it is 1, `readout` = {code, 6'b0}. When it is 0, `readout` = {6'b0, code}. A change shows on the cycle after the write, even while a conversion runs.
- R10: With control bit 2 (auto-trigger) set and trigger code s (`regSel`=2, bits 2:0) in 1..7, a rising edge on `trigIn[s-1]` starts a conversion on the next edge. A steady high level, an edge while busy, or any edge with auto-trigger clear starts nothing.
- R11: Changing the trigger code from a source that is low to a source that is high counts as a rising edge and starts a conversion.
- R12: With auto-trigger set and trigger code 0, every completion immediately starts the next conversion and `busy` stays high. Selecting code 0 does not start a conversion by itself, even with `flag` set.
- R13: A start written with enable clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 select, 2 trigger |
| regWdata | input | 8 | Write data |
| trigIn | input | 7 | Auto-trigger source lines |
| globalIe | input | 1 | Global interrupt enable |
| irqAck | input | 1 | Interrupt taken; clears the flag |
| cvtValid | input | 1 | Converter code valid |
| cvtData | input | 10 | Converter code |
| busy | output | 1 | Start bit read value |
| flag | output | 1 | Conversion complete flag |
| irq | output | 1 | Interrupt request |
| sampleStart | output | 1 | One-cycle pulse at the start of a real conversion |
| eocReq | output | 1 | End-of-conversion request to the converter |
| activeChan | output | 4 | Channel applied to the converter |
| activeRef | output | 2 | Reference applied to the converter |
| readout | output | 16 | Aligned result |

## Verification
The checker watches a set of cycle-level rules on every cycle. A request to the converter only happens while busy. A flag rise always follows an accepted handshake. Disabling the block leaves it idle on the next cycle. The applied channel holds still during a conversion. The interrupt is never raised without the flag and the global enable. The readout always has one padding field at zero. Other behaviour depends on counting a whole conversion or on history, and only the bench scenarios show it: the 25- and 13-tick timings at several dividers, the edge versus level behaviour of the trigger, the edge created by switching the source, back-to-back free-running captures, and which channel a result was actually taken on.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W  = 8;
  localparam int CHAN_W = 4;
  localparam int REF_W  = 2;
  localparam int PS_W   = 3;
  localparam int TSEL_W = 3;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_MUX  = 2'd1;
  localparam logic [1:0] REG_TRIG = 2'd2;

  // control register fields
  localparam int CB_EN   = 0;
  localparam int CB_GO   = 1;
  localparam int CB_AUTO = 2;
  localparam int CB_CLR  = 3;
  localparam int CB_IE   = 4;
  localparam int CB_PS   = 5;
  // select register fields
  localparam int MB_CHAN = 0;
  localparam int MB_REF  = 4;
  localparam int MB_LEFT = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_CONV, ST_WAIT} seqState_t;

  typedef struct packed {
    logic loadSel;
    logic loadResult;
  } dpStrobe_t;
endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic [SEL_W-1:0] divSel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [SEL_W-1:0] effSel;

  assign effSel = (divSel == '0) ? SEL_W'(1) : divSel;

  generate
    for (genvar g = 0; g < CNT_W; g++) begin : gMask
      assign mask[g] = (SEL_W'(g) < effSel);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign tick = ((cnt & mask) == mask);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_TICKS = 13,
  parameter int INIT_TICKS = 25,
  parameter int NUM_TRIG   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWdata,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic             globalIe,
  input  logic             irqAck,
  input  logic             cvtValid,
  output logic             busy,
  output logic             flag,
  output logic             irq,
  output logic             sampleStart,
  output logic             eocReq,
  output dpStrobe_t        strobe
);
  localparam int TICK_W     = $clog2(INIT_TICKS + 1);
  localparam int PREP_TICKS = INIT_TICKS - CONV_TICKS;

  seqState_t        state;
  logic [TICK_W-1:0] tickCnt;
  logic             enableQ, autoQ, irqEnQ, needInitQ, flagQ, trigPrevQ, sampleQ;
  logic [PS_W-1:0]  psSelQ;
  logic [TSEL_W-1:0] trigSelQ;

  logic ctrlWr, trigWr, enNext, startWr, trigLevel, trigEdge, freeRun;
  logic goStart, useInit, capture, flagClr, psClear, tick;

  assign ctrlWr  = regWr && (regSel == REG_CTRL);
  assign trigWr  = regWr && (regSel == REG_TRIG);
  assign enNext  = ctrlWr ? regWdata[CB_EN] : enableQ;
  assign startWr = ctrlWr && regWdata[CB_GO] && regWdata[CB_EN];
  assign freeRun = autoQ && (trigSelQ == '0);

  always_comb begin
    trigLevel = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (int'(trigSelQ) == i + 1) trigLevel = trigIn[i];
    end
  end

  assign trigEdge = autoQ && (trigSelQ != '0) && trigLevel && !trigPrevQ;
  assign goStart  = (state == ST_IDLE) && enNext && (startWr || trigEdge);
  assign useInit  = needInitQ || (enNext && !enableQ);
  assign capture  = (state == ST_WAIT) && cvtValid && enNext;
  assign flagClr  = (ctrlWr && regWdata[CB_CLR]) || irqAck;
  assign psClear  = goStart || (capture && freeRun);

  adc_seq_presc #(.SEL_W(PS_W)) presc_i (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (psClear),
    .divSel (psSelQ),
    .tick   (tick)
  );

  // configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      autoQ    <= 1'b0;
      irqEnQ   <= 1'b0;
      psSelQ   <= '0;
      trigSelQ <= '0;
      trigPrevQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enableQ <= regWdata[CB_EN];
        autoQ   <= regWdata[CB_AUTO];
        irqEnQ  <= regWdata[CB_IE];
        psSelQ  <= regWdata[CB_PS +: PS_W];
      end
      if (trigWr) trigSelQ <= regWdata[TSEL_W-1:0];
      trigPrevQ <= trigLevel;
    end
  end

  // sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      needInitQ <= 1'b0;
      sampleQ   <= 1'b0;
    end else begin
      sampleQ <= 1'b0;
      if (enNext && !enableQ) needInitQ <= 1'b1;
      if (!enNext) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (goStart) begin
            tickCnt <= '0;
            if (useInit) begin
              state <= ST_PREP;
            end else begin
              state   <= ST_CONV;
              sampleQ <= 1'b1;
            end
          end
          ST_PREP: if (tick) begin
            if (tickCnt == TICK_W'(PREP_TICKS - 1)) begin
              state     <= ST_CONV;
              tickCnt   <= '0;
              sampleQ   <= 1'b1;
              needInitQ <= 1'b0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          ST_CONV: if (tick) begin
            if (tickCnt == TICK_W'(CONV_TICKS - 1)) state <= ST_WAIT;
            else tickCnt <= tickCnt + 1'b1;
          end
          ST_WAIT: if (cvtValid) begin
            if (freeRun) begin
              state   <= ST_CONV;
              tickCnt <= '0;
              sampleQ <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (capture) flagQ <= 1'b1;
    else if (flagClr) flagQ <= 1'b0;
  end

  assign busy        = (state != ST_IDLE);
  assign eocReq      = (state == ST_WAIT);
  assign sampleStart = sampleQ;
  assign flag        = flagQ;
  assign irq         = flagQ && irqEnQ && globalIe;

  assign strobe.loadSel    = (state == ST_IDLE) || capture;
  assign strobe.loadResult = capture;
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  input  dpStrobe_t         strobe,
  input  logic [RES_W-1:0]  cvtData,
  output logic [CHAN_W-1:0] activeChan,
  output logic [REF_W-1:0]  activeRef,
  output logic [OUT_W-1:0]  readout
);
  localparam int PAD_W = OUT_W - RES_W;

  logic [CHAN_W-1:0] chanQ;
  logic [REF_W-1:0]  refQ;
  logic              leftQ;
  logic [RES_W-1:0]  resultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanQ <= '0;
      refQ  <= '0;
      leftQ <= 1'b0;
    end else if (regWr && regSel == REG_MUX) begin
      chanQ <= regWdata[MB_CHAN +: CHAN_W];
      refQ  <= regWdata[MB_REF +: REF_W];
      leftQ <= regWdata[MB_LEFT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeChan <= '0;
      activeRef  <= '0;
    end else if (strobe.loadSel) begin
      activeChan <= chanQ;
      activeRef  <= refQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  resultQ <= '0;
    else if (strobe.loadResult) resultQ <= cvtData;
  end

  assign readout = leftQ ? {resultQ, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, resultQ};
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int OUT_W      = 16,
  parameter int CONV_TICKS = 13,
  parameter int INIT_TICKS = 25,
  parameter int NUM_TRIG   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [1:0]          regSel,
  input  logic [7:0]          regWdata,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic                globalIe,
  input  logic                irqAck,
  input  logic                cvtValid,
  input  logic [RES_W-1:0]    cvtData,
  output logic                busy,
  output logic                flag,
  output logic                irq,
  output logic                sampleStart,
  output logic                eocReq,
  output logic [3:0]          activeChan,
  output logic [1:0]          activeRef,
  output logic [OUT_W-1:0]    readout
);
  dpStrobe_t strobe;

  adc_seq_ctrl #(
    .CONV_TICKS (CONV_TICKS),
    .INIT_TICKS (INIT_TICKS),
    .NUM_TRIG   (NUM_TRIG)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regSel      (regSel),
    .regWdata    (regWdata),
    .trigIn      (trigIn),
    .globalIe    (globalIe),
    .irqAck      (irqAck),
    .cvtValid    (cvtValid),
    .busy        (busy),
    .flag        (flag),
    .irq         (irq),
    .sampleStart (sampleStart),
    .eocReq      (eocReq),
    .strobe      (strobe)
  );

  adc_seq_dp #(
    .RES_W (RES_W),
    .OUT_W (OUT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .strobe     (strobe),
    .cvtData    (cvtData),
    .activeChan (activeChan),
    .activeRef  (activeRef),
    .readout    (readout)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [1:0]       regSel,
  input logic [7:0]       regWdata,
  input logic             cvtValid,
  input logic             globalIe,
  input logic             busy,
  input logic             flag,
  input logic             irq,
  input logic             sampleStart,
  input logic             eocReq,
  input logic [3:0]       activeChan,
  input logic [OUT_W-1:0] readout
);
  a_r2_request_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    eocReq |-> busy);

  a_r6_flag_after_handshake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(eocReq && cvtValid));

  a_r5_disable_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 2'd0 && !regWdata[0]) |=> (!busy && !eocReq));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flag && globalIe));

  a_r8_channel_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(eocReq && cvtValid)) |=> $stable(activeChan));

  a_r9_one_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (readout[OUT_W-1:RES_W] == '0) || (readout[OUT_W-RES_W-1:0] == '0));

  a_r1_sample_in_conv: assert property (@(posedge clk) disable iff (!rstN)
    sampleStart |-> busy);

  a_r1_sample_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleStart |=> !sampleStart);
endmodule

bind adc_seq adc_seq_chk #(.RES_W(RES_W), .OUT_W(OUT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .regWr       (regWr),
  .regSel      (regSel),
  .regWdata    (regWdata),
  .cvtValid    (cvtValid),
  .globalIe    (globalIe),
  .busy        (busy),
  .flag        (flag),
  .irq         (irq),
  .sampleStart (sampleStart),
  .eocReq      (eocReq),
  .activeChan  (activeChan),
  .readout     (readout)
);

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [7:0]  regWdata = 8'd0;
  logic [6:0]  trigIn = 7'd0;
  logic        globalIe = 1'b0;
  logic        irqAck = 1'b0;
  logic        cvtValid;
  logic [9:0]  cvtData;
  logic        busy, flag, irq, sampleStart, eocReq;
  logic [3:0]  activeChan;
  logic [1:0]  activeRef;
  logic [15:0] readout;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [9:0] expQ[$];
  logic [9:0] lastExp = 10'd0;
  bit   benchLeft = 1'b0;
  logic [5:0] expSeq = 6'd5;
  logic [2:0] curPs = 3'd1;
  bit   curAuto = 1'b0;

  always #5 clk = ~clk;

  adc_seq dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .trigIn(trigIn), .globalIe(globalIe), .irqAck(irqAck), .cvtValid(cvtValid),
    .cvtData(cvtData), .busy(busy), .flag(flag), .irq(irq), .sampleStart(sampleStart),
    .eocReq(eocReq), .activeChan(activeChan), .activeRef(activeRef), .readout(readout)
  );

  // converter model: answers two cycles after a request
  logic [3:0] modelChan;
  logic [5:0] modelSeq;
  logic       waitCnt;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cvtValid <= 1'b0; modelChan <= 4'd0; modelSeq <= 6'd5; waitCnt <= 1'b0;
    end else begin
      if (sampleStart) modelChan <= activeChan;
      if (!eocReq) begin
        cvtValid <= 1'b0; waitCnt <= 1'b0;
      end else if (cvtValid) begin
        cvtValid <= 1'b0; modelSeq <= modelSeq + 6'd1;
      end else if (waitCnt) begin
        cvtValid <= 1'b1; waitCnt <= 1'b0;
      end else begin
        waitCnt <= 1'b1;
      end
    end
  end
  assign cvtData = {modelChan, modelSeq};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  function automatic logic [7:0] ctrlByte(bit en, bit st, bit au, bit cl, bit ie, logic [2:0] ps);
    return {ps, ie, cl, au, st, en};
  endfunction

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic pushExp(input logic [3:0] chan);
    expQ.push_back({chan, expSeq});
    expSeq = expSeq + 6'd1;
  endtask

  task automatic startConv();
    wrReg(2'd0, ctrlByte(1, 1, curAuto, 0, 1, curPs));
  endtask

  task automatic clrFlag();
    wrReg(2'd0, ctrlByte(1, 0, curAuto, 1, 1, curPs));
  endtask

  task automatic waitCapture(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!flag && n < 3000);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eocReq && cvtValid) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          chk(1'b0, "R1 unexpected capture", readout, 0);
        end else begin
          logic [9:0] e;
          logic [15:0] e16;
          e = expQ.pop_front();
          lastExp = e;
          e16 = benchLeft ? {e, 6'b0} : {6'b0, e};
          chk(readout == e16, "R8/R9 captured result", readout, e16);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !flag && !irq && !eocReq, "R2 reset idle", {busy, flag, irq, eocReq}, 0);
    chk(readout == 16'd0, "R9 reset readout", readout, 0);

    // R1: enable with start clear does nothing
    wrReg(2'd0, ctrlByte(1, 0, 0, 0, 1, curPs));
    seen = 1'b0;
    repeat (10) begin @(negedge clk); if (busy || sampleStart) seen = 1'b1; end
    chk(!seen, "R1 start bit zero ignored", seen, 0);

    // R3/R4: first conversion after enable is extended
    pushExp(4'd0);
    startConv();
    chk(busy, "R1 busy after start", busy, 1);
    waitCapture(n);
    chk(n == 25 * 2 + 3, "R3 initial conversion length", n, 25 * 2 + 3);
    chk(!busy, "R2 busy falls with flag", busy, 0);
    chk(!irq, "R7 irq held by global enable", irq, 0);
    globalIe = 1'b1;
    @(negedge clk);
    chk(irq, "R7 irq raised", irq, 1);
    wrReg(2'd0, ctrlByte(1, 0, 0, 0, 1, curPs));
    chk(flag, "R6 write zero keeps flag", flag, 1);
    clrFlag();
    chk(!flag && !irq, "R6 write one clears flag", {flag, irq}, 0);

    // R3: normal conversion
    pushExp(4'd0);
    startConv();
    waitCapture(n);
    chk(n == 13 * 2 + 3, "R3 normal conversion length", n, 13 * 2 + 3);
    clrFlag();
    pushExp(4'd0);
    startConv();
    repeat (10) @(negedge clk);
    chk(busy, "R2 busy mid conversion", busy, 1);
    waitCapture(n);

    // R4: divide by 8
    curPs = 3'd3;
    clrFlag();
    pushExp(4'd0);
    startConv();
    waitCapture(n);
    chk(n == 13 * 8 + 3, "R4 divider code 3", n, 13 * 8 + 3);
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    chk(!flag, "R6 ack clears flag", flag, 0);
    curPs = 3'd1;
    clrFlag();

    // R8: deferred channel and reference
    wrReg(2'd1, 8'h12);
    @(negedge clk);
    chk(activeChan == 4'd2 && activeRef == 2'd1, "R8 idle select follows",
        {activeChan, activeRef}, {4'd2, 2'd1});
    pushExp(4'd2);
    startConv();
    repeat (5) @(negedge clk);
    wrReg(2'd1, 8'h39);
    repeat (3) @(negedge clk);
    chk(activeChan == 4'd2 && activeRef == 2'd1, "R8 select held during conversion",
        {activeChan, activeRef}, {4'd2, 2'd1});
    waitCapture(n);
    chk(activeChan == 4'd9 && activeRef == 2'd3, "R8 select applied at completion",
        {activeChan, activeRef}, {4'd9, 2'd3});

    // R9: alignment acts at once
    wrReg(2'd1, 8'h79);
    benchLeft = 1'b1;
    chk(readout == {lastExp, 6'b0}, "R9 left alignment", readout, {lastExp, 6'b0});
    clrFlag();
    pushExp(4'd9);
    startConv();
    repeat (5) @(negedge clk);
    wrReg(2'd1, 8'h39);
    benchLeft = 1'b0;
    chk(busy && readout == {6'b0, lastExp}, "R9 alignment during conversion",
        readout, {6'b0, lastExp});
    waitCapture(n);

    // R5: abort
    clrFlag();
    startConv();
    repeat (8) @(negedge clk);
    wrReg(2'd0, ctrlByte(0, 0, 0, 0, 1, curPs));
    chk(!busy && !eocReq, "R5 abort idles", {busy, eocReq}, 0);
    repeat (80) @(negedge clk);
    chk(!flag && expQ.size() == 0, "R5 no result after abort", flag, 0);
    pushExp(4'd9);
    startConv();
    waitCapture(n);
    chk(n == 25 * 2 + 3, "R3 start with enable is extended", n, 25 * 2 + 3);

    // R13: start without enable
    clrFlag();
    wrReg(2'd0, ctrlByte(0, 1, 0, 0, 1, curPs));
    repeat (5) @(negedge clk);
    chk(!busy, "R13 start while disabled ignored", busy, 0);
    wrReg(2'd0, ctrlByte(1, 0, 0, 0, 1, curPs));
    pushExp(4'd9);
    startConv();
    waitCapture(n);
    chk(n == 25 * 2 + 3, "R3 re-enable is extended", n, 25 * 2 + 3);

    // R10: auto trigger on a rising edge
    clrFlag();
    wrReg(2'd2, 8'd3);
    curAuto = 1'b1;
    wrReg(2'd0, ctrlByte(1, 0, 1, 0, 1, curPs));
    pushExp(4'd9);
    @(negedge clk); trigIn[2] = 1'b1;
    @(negedge clk);
    chk(busy, "R10 trigger edge starts", busy, 1);
    waitCapture(n);
    chk(n == 13 * 2 + 3, "R10 triggered conversion length", n, 13 * 2 + 3);
    repeat (10) @(negedge clk);
    chk(!busy, "R10 steady level no retrigger", busy, 0);
    trigIn[2] = 1'b0;
    curAuto = 1'b0;
    wrReg(2'd0, ctrlByte(1, 0, 0, 0, 1, curPs));
    @(negedge clk); trigIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy, "R10 edge ignored without auto trigger", busy, 0);
    trigIn[2] = 1'b0;

    // R11: switching source from low to high
    curAuto = 1'b1;
    clrFlag();
    trigIn[4] = 1'b1;
    wrReg(2'd2, 8'd1);
    repeat (3) @(negedge clk);
    chk(!busy, "R11 switch to low source no start", busy, 0);
    pushExp(4'd9);
    wrReg(2'd2, 8'd5);
    waitCapture(n);
    chk(n == 13 * 2 + 4, "R11 source switch triggers", n, 13 * 2 + 4);
    trigIn[4] = 1'b0;

    // R12: free running
    wrReg(2'd2, 8'd0);
    repeat (10) @(negedge clk);
    chk(!busy && flag, "R12 selecting free run does not trigger", {busy, flag}, 2'b01);
    pushExp(4'd9);
    pushExp(4'd9);
    wrReg(2'd0, ctrlByte(1, 1, 1, 1, 1, curPs));
    waitCapture(n);
    chk(n == 13 * 2 + 3, "R12 first free run capture", n, 13 * 2 + 3);
    chk(busy, "R12 restarts without gap", busy, 1);
    clrFlag();
    waitCapture(n);
    chk(n == 13 * 2 + 1, "R12 second free run capture", n, 13 * 2 + 1);
    curAuto = 1'b0;
    wrReg(2'd0, ctrlByte(0, 0, 0, 1, 1, curPs));
    repeat (40) @(negedge clk);
    chk(!busy && expQ.size() == 0, "R12 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule